// File: doc/BRIEF.md
# GPIO Edge Detect and Wake Unit

This unit watches the synchronised levels of 128 GPIO pins, grouped into four banks of 32. It captures enabled rising and falling transitions on pins that are configured as inputs. Each capture sets a bit in a per-bank status register. The bit stays set until software clears it by writing a 1 to it. The status of all banks is folded into three registered interrupt lines. Pins 0 and 1 of bank 0 each have a dedicated line, and every other status bit shares a single OR line.

A second path serves a halted processor. While `halted` is high, any level change on an input pin that lies in the fixed wake-capable mask of its bank raises a one-cycle `wake` pulse. This path ignores the edge enables. Software reaches the enable and status registers through a simple 32-bit register bus, with combinational reads and single-cycle writes. The direction vector comes from the neighbouring GPIO register block, where 1 means output.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every enable register and every status register reads 0, and `irq_pin0`, `irq_pin1`, `irq_other` and `wake` are low.
- R2: The rising-enable registers sit at byte offsets 0x030, 0x034, 0x038, 0x130 and the falling-enable registers at 0x03C, 0x040, 0x044, 0x13C (banks 0 to 3). Each reads back the last value written.
- R3: A 0-to-1 change of pin n, when its rising-enable bit is 1 and its direction bit is 0, sets status bit n. The status registers sit at 0x048, 0x04C, 0x050, 0x148 (banks 0 to 3). The bit reads back as 1 after the clock edge that sees the new level.
- R4: A 1-to-0 change of pin n, when its falling-enable bit is 1 and its direction bit is 0, sets status bit n.
- R5: A pin whose direction bit is 1 never sets its status bit, whatever its enables are.
- R6: Status bits are sticky. A write to a status register clears exactly the bits written as 1 and leaves the others unchanged.
- R7: When a capture and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R8: `irq_pin0` and `irq_pin1` equal bank-0 status bits 0 and 1 as they were one clock earlier.
- R9: `irq_other` is the OR of bank-0 status bits 31..2 and all bits of banks 1 to 3, as they were one clock earlier.
- R10: While `halted` is high, a level change on an input pin in the wake mask makes `wake` high for exactly the one cycle after the edge that sees the change, independent of the enables. The masks are 0x8003FE1B, 0x002001FC, 0xEC080000, 0x0012007F for banks 0 to 3. Nothing happens when `halted` is low, when the pin is outside the mask, or when the pin is an output.
- R11: A wake-capable change seen during the cycle in which `wake` is high does not start a second pulse.
- R12: Reads of unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| dir_in | input | 128 | Pin direction, 1 = output |
| pin_in | input | 128 | Synchronised pin levels |
| halted | input | 1 | Processor is halted |
| irq_pin0 | output | 1 | Interrupt for bank-0 status bit 0 |
| irq_pin1 | output | 1 | Interrupt for bank-0 status bit 1 |
| irq_other | output | 1 | Interrupt for all remaining status bits |
| wake | output | 1 | One-cycle wake request |

## Verification
The bench drives a capture and a clearing write into the same status bit in the same cycle. A design that gave the clear priority would lose that event. It measures the one-cycle lag of the interrupt lines, which would show up as an early or missing assertion if the registering were wrong. It toggles output pins with both enables set, to catch capture logic that ignores direction. The wake path is tested with pins inside and outside the mask, with `halted` low, and with a second change that arrives during the pulse. A faulty state machine would stretch the pulse, fire twice, or fire while the processor runs.

// File: rtl/gei_pkg.sv
package gei_pkg;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_RISE,
        KIND_FALL,
        KIND_STAT
    } reg_kind_e;

    typedef enum logic [1:0] {
        WK_RUN,
        WK_WATCH,
        WK_FIRE
    } wake_state_e;

    // byte offset of a per-bank register; bank 3 sits in the upper page
    function automatic logic [11:0] reg_offset(reg_kind_e kind, int bank);
        logic [11:0] base;
        case (kind)
            KIND_RISE: base = 12'h030;
            KIND_FALL: base = 12'h03C;
            default:   base = 12'h048;
        endcase
        case (bank)
            0:       reg_offset = base;
            1:       reg_offset = base + 12'h004;
            2:       reg_offset = base + 12'h008;
            default: reg_offset = base + 12'h100;
        endcase
    endfunction

    // fixed wake-capable pins of each bank
    function automatic logic [31:0] wake_mask(int bank);
        case (bank)
            0:       wake_mask = 32'h8003_FE1B;
            1:       wake_mask = 32'h0020_01FC;
            2:       wake_mask = 32'hEC08_0000;
            default: wake_mask = 32'h0012_007F;
        endcase
    endfunction

endpackage

// File: rtl/gei_regs.sv
module gei_regs
    import gei_pkg::*;
#(
    parameter int BANKS = 4,
    parameter int W     = 32,
    parameter int AW    = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [AW-1:0]             bus_addr,
    input  logic                      bus_wr,
    input  logic [W-1:0]              bus_wdata,
    input  logic [BANKS-1:0][W-1:0]   stat_i,
    output logic [BANKS-1:0][W-1:0]   rise_en_o,
    output logic [BANKS-1:0][W-1:0]   fall_en_o,
    output logic [BANKS-1:0][W-1:0]   clr_o,
    output logic [W-1:0]              rdata_o
);
    logic [BANKS-1:0] hit_rise, hit_fall, hit_stat;

    always_comb begin
        for (int b = 0; b < BANKS; b++) begin
            hit_rise[b] = (bus_addr == AW'(reg_offset(KIND_RISE, b)));
            hit_fall[b] = (bus_addr == AW'(reg_offset(KIND_FALL, b)));
            hit_stat[b] = (bus_addr == AW'(reg_offset(KIND_STAT, b)));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en_o <= '0;
            fall_en_o <= '0;
        end else if (bus_wr) begin
            for (int b = 0; b < BANKS; b++) begin
                if (hit_rise[b]) rise_en_o[b] <= bus_wdata;
                if (hit_fall[b]) fall_en_o[b] <= bus_wdata;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int b = 0; b < BANKS; b++) begin
            clr_o[b] = (bus_wr && hit_stat[b]) ? bus_wdata : '0;
            if (hit_rise[b]) rdata_o = rise_en_o[b];
            if (hit_fall[b]) rdata_o = fall_en_o[b];
            if (hit_stat[b]) rdata_o = stat_i[b];
        end
    end
endmodule

// File: rtl/gei_bank.sv
module gei_bank #(
    parameter int          W     = 32,
    parameter logic [31:0] WMASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic [W-1:0] clr,
    output logic [W-1:0] stat,
    output logic         wake_hit
);
    logic [W-1:0] prev_q;
    logic [W-1:0] rose, fell, capture;

    always_comb begin
        rose     = pin & ~prev_q;
        fell     = ~pin & prev_q;
        capture  = ((rose & rise_en) | (fell & fall_en)) & ~dir;
        wake_hit = |((pin ^ prev_q) & ~dir & WMASK[W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            stat   <= '0;
        end else begin
            prev_q <= pin;
            stat   <= (stat & ~clr) | capture;   // capture beats clear
        end
    end
endmodule

// File: rtl/gei_wake.sv
module gei_wake
    import gei_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halted,
    input  logic hit,
    output logic wake
);
    wake_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WK_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WK_RUN, WK_WATCH: begin
                if (halted && hit) state_d = WK_FIRE;
                else if (halted)   state_d = WK_WATCH;
                else               state_d = WK_RUN;
            end
            WK_FIRE: state_d = halted ? WK_WATCH : WK_RUN;
            default: state_d = WK_RUN;
        endcase
    end

    always_comb begin
        wake = (state_q == WK_FIRE);
    end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gei_pkg::*;
#(
    parameter int BANKS = 4,
    parameter int W     = 32,
    parameter int AW    = 12,
    localparam int NPIN = BANKS * W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [W-1:0]    bus_wdata,
    output logic [W-1:0]    bus_rdata,
    input  logic [NPIN-1:0] dir_in,
    input  logic [NPIN-1:0] pin_in,
    input  logic            halted,
    output logic            irq_pin0,
    output logic            irq_pin1,
    output logic            irq_other,
    output logic            wake
);
    logic [BANKS-1:0][W-1:0] stat_all, rise_en, fall_en, clr;
    logic [BANKS-1:0]        bank_hit;

    gei_regs #(.BANKS(BANKS), .W(W), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .stat_i    (stat_all),
        .rise_en_o (rise_en),
        .fall_en_o (fall_en),
        .clr_o     (clr),
        .rdata_o   (bus_rdata)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        gei_bank #(.W(W), .WMASK(wake_mask(b))) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (pin_in[b*W +: W]),
            .dir      (dir_in[b*W +: W]),
            .rise_en  (rise_en[b]),
            .fall_en  (fall_en[b]),
            .clr      (clr[b]),
            .stat     (stat_all[b]),
            .wake_hit (bank_hit[b])
        );
    end

    gei_wake u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .halted (halted),
        .hit    (|bank_hit),
        .wake   (wake)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pin0  <= 1'b0;
            irq_pin1  <= 1'b0;
            irq_other <= 1'b0;
        end else begin
            irq_pin0  <= stat_all[0][0];
            irq_pin1  <= stat_all[0][1];
            irq_other <= (|stat_all[0][W-1:2]) | (|stat_all[BANKS-1:1]);
        end
    end
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
    parameter int BANKS = 4,
    parameter int W     = 32,
    parameter int AW    = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [AW-1:0]           bus_addr,
    input logic                    bus_wr,
    input logic [W-1:0]            bus_wdata,
    input logic [BANKS*W-1:0]      dir_in,
    input logic                    halted,
    input logic                    irq_pin0,
    input logic                    irq_pin1,
    input logic                    irq_other,
    input logic                    wake,
    input logic [BANKS-1:0][W-1:0] stat_all
);
    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);  // R11
    AST_WAKE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $past(halted));  // R10
    AST_OUTPUT_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_all[0][0] && dir_in[0]) |=> !stat_all[0][0]);  // R5
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_all[0][0] && !(bus_wr && bus_addr == AW'(12'h048) && bus_wdata[0]))
        |=> stat_all[0][0]);  // R6
    AST_IRQ0_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pin0 == $past(stat_all[0][0]));  // R8
    AST_IRQ1_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pin1 == $past(stat_all[0][1]));  // R8
    AST_IRQ_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_other == $past((|stat_all[0][W-1:2]) | (|stat_all[BANKS-1:1])));  // R9
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.BANKS(BANKS), .W(W), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .dir_in    (dir_in),
    .halted    (halted),
    .irq_pin0  (irq_pin0),
    .irq_pin1  (irq_pin1),
    .irq_other (irq_other),
    .wake      (wake),
    .stat_all  (stat_all)
);

// File: tb/gpio_edge_irq_test.sv
module gpio_edge_irq_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [127:0] dir_in = '0;
    logic [127:0] pin_in = '0;
    logic         halted = 1'b0;
    logic         irq_pin0, irq_pin1, irq_other, wake;
    int           n_run = 0;
    int           n_bad = 0;

    always #5 clk = ~clk;

    gpio_edge_irq uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dir_in(dir_in),
        .pin_in(pin_in), .halted(halted), .irq_pin0(irq_pin0),
        .irq_pin1(irq_pin1), .irq_other(irq_other), .wake(wake)
    );

    typedef struct packed {
        logic [1:0]  bank;
        logic [31:0] ren, fen, dir, p0, p1, expv;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{2'd0, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 32'h0000_00F0, 32'h0000_00F0},
        '{2'd1, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_0000, 32'h0000_FFFF},
        '{2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFF00_0000, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'h00FF_FFFF},
        '{2'd3, 32'h0000_FFFF, 32'hFFFF_0000, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0000_FFFF},
        '{2'd3, 32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0},
        '{2'd1, 32'hAAAA_AAAA, 32'h5555_5555, 32'h0, 32'h0000_FFFF, 32'hFFFF_0000, 32'hAAAA_5555}
    };

    function automatic logic [11:0] offs(int kind, int bank);
        logic [11:0] base;
        base = (kind == 0) ? 12'h030 : (kind == 1) ? 12'h03C : 12'h048;
        return (bank == 3) ? base + 12'h100 : base + 12'(4 * bank);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
        n_run++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, expv);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        for (int b = 0; b < 4; b++) begin
            rd(offs(0, b), r); check("R1 rise reset", r, 0);
            rd(offs(1, b), r); check("R1 fall reset", r, 0);
            rd(offs(2, b), r); check("R1 stat reset", r, 0);
        end
        check("R1 outputs low", {28'd0, irq_pin0, irq_pin1, irq_other, wake}, 0);

        // vector table: R3 R4 R5
        foreach (VECS[i]) begin
            int b;
            b = int'(VECS[i].bank);
            dir_in[b*32 +: 32] = VECS[i].dir;
            wr(offs(0, b), 0);
            wr(offs(1, b), 0);
            pin_in[b*32 +: 32] = VECS[i].p0;
            step(2);
            wr(offs(0, b), VECS[i].ren);
            wr(offs(1, b), VECS[i].fen);
            wr(offs(2, b), 32'hFFFF_FFFF);
            pin_in[b*32 +: 32] = VECS[i].p1;
            step(1);
            rd(offs(2, b), r);
            check($sformatf("R3/R4/R5 vector %0d", i), r, VECS[i].expv);
        end

        // R2 enable readback on the upper page
        wr(12'h130, 32'h1234_5678);
        wr(12'h13C, 32'h9ABC_DEF0);
        rd(12'h130, r); check("R2 rise bank3", r, 32'h1234_5678);
        rd(12'h13C, r); check("R2 fall bank3", r, 32'h9ABC_DEF0);
        wr(12'h130, 0); wr(12'h13C, 0);

        // R12 unmapped
        wr(12'h0FC, 32'hFFFF_FFFF);
        rd(12'h0FC, r); check("R12 unmapped read", r, 0);
        rd(12'h04C, r); check("R12 status untouched", r, 32'hAAAA_5555);

        // R6 partial clear
        wr(12'h04C, 32'h0000_FFFF);
        rd(12'h04C, r); check("R6 partial W1C", r, 32'hAAAA_0000);
        check("R9 shared line set", {31'd0, irq_other}, 1);

        // clear everything, disable enables
        for (int b = 0; b < 4; b++) begin
            wr(offs(0, b), 0); wr(offs(1, b), 0); wr(offs(2, b), 32'hFFFF_FFFF);
        end
        step(1);
        check("R9 shared line clear", {31'd0, irq_other}, 0);

        // R9 via bank 2 bit 3
        dir_in[64 +: 32] = 0;
        wr(offs(0, 2), 32'h0000_0008);
        pin_in[67] = ~pin_in[67];
        if (pin_in[67] == 1'b0) begin
            step(1); pin_in[67] = 1'b1;
        end
        step(1);
        check("R9 lag", {31'd0, irq_other}, 0);
        step(1);
        check("R9 bank2 raises shared", {31'd0, irq_other}, 1);
        wr(offs(2, 2), 32'hFFFF_FFFF);
        step(1);

        // R8 dedicated lines
        dir_in[31:0] = 0;
        pin_in[1:0] = 2'b00;
        step(2);
        wr(offs(0, 0), 32'h0000_0103);
        pin_in[0] = 1'b1;
        step(1);
        check("R8 irq0 lag", {31'd0, irq_pin0}, 0);
        step(1);
        check("R8 irq0 set", {30'd0, irq_pin0, irq_pin1}, 2'b10);
        check("R8 other stays low", {31'd0, irq_other}, 0);
        pin_in[1] = 1'b1;
        step(2);
        check("R8 irq1 set", {30'd0, irq_pin0, irq_pin1}, 2'b11);
        wr(offs(2, 0), 32'h3);
        step(1);
        check("R8 both cleared", {30'd0, irq_pin0, irq_pin1}, 2'b00);

        // R7 capture wins over clear in the same cycle
        pin_in[8] = 1'b0;
        step(1);
        @(negedge clk);
        pin_in[8] = 1'b1;
        bus_addr = 12'h048; bus_wdata = 32'h0000_0100; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(12'h048, r);
        check("R7 set beats clear", r & 32'h100, 32'h100);

        // R10 wake
        wr(offs(0, 0), 0); wr(offs(1, 0), 0);
        halted = 1'b1;
        step(2);
        pin_in[0] = ~pin_in[0];
        step(1);
        check("R10 wake pulse", {31'd0, wake}, 1);
        pin_in[0] = ~pin_in[0];       // during the pulse
        step(1);
        check("R10 pulse one cycle", {31'd0, wake}, 0);
        step(1);
        check("R11 no second pulse", {31'd0, wake}, 0);
        pin_in[2] = ~pin_in[2];       // outside mask
        step(1);
        check("R10 outside mask", {31'd0, wake}, 0);
        dir_in[0] = 1'b1;
        pin_in[0] = ~pin_in[0];       // output pin
        step(1);
        check("R10 output pin", {31'd0, wake}, 0);
        dir_in[0] = 1'b0;
        halted = 1'b0;
        step(1);
        pin_in[0] = ~pin_in[0];       // not halted
        step(1);
        check("R10 not halted", {31'd0, wake}, 0);
        step(1);
        check("R10 not halted later", {31'd0, wake}, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule